// File: doc/BRIEF.md
# UART FIFO Interrupt and Line Status Logic

This block keeps the interrupt enables, the line status byte and the interrupt request for a UART with 32-entry receive and transmit FIFOs. The serial shifters and the FIFO arrays sit outside it. They report the receive fill count, a per-character error vector on each transfer into the receive FIFO, a flag for errored entries still queued, and the transmit empty and shifter idle flags.

A host loads a four-bit enable register and reads an interrupt status code. Three sources are arbitrated in a fixed order: receiver errors, receive fill at or above a selectable trigger level, and transmit empty. The receive-data source needs no acknowledge because it follows the fill count both up and down. With the FIFOs on and every enable cleared, the block is in polled mode. The request line then stays low, but every line status bit keeps tracking the FIFOs.

Top module: `uart_irq_status`

## Requirements
- R1: `ier` resets to 0 and loads `ier_wdata` on a cycle where `ier_wr` is high, visible from the next cycle.
- R2: With `fifo_en` high and `ier[0]` set, the receive-data source is pending exactly while `rx_count` is at or above the trigger level. It clears when the count falls below the level, with no acknowledge. With `fifo_en` low the level is 1.
- R3: `trig_sel` picks the trigger level: 0 gives 8, 1 gives 16, 2 gives 24, 3 gives 28 entries.
- R4: `lsr[0]` (data ready) is 1 whenever `rx_count` is nonzero and 0 when it is zero.
- R5: `lsr[4:1]` hold the OR of `rx_err` over every cycle with `rx_push` high. A cycle with `lsr_rd` high clears them; errors pushed in that same cycle are still kept.
- R6: `lsr[5]` equals `tx_empty`, `lsr[6]` equals `tx_empty` AND `tx_idle`, and `lsr[7]` equals `rx_bad`.
- R7: The line-status source is pending while `ier[2]` is set and `lsr[4:1]` is nonzero.
- R8: A transmit-empty flag sets when `tx_empty` is 1 and was 0 in the previous cycle (0 taken at reset). It also sets when an `ier` write raises bit 1 from 0 while `tx_empty` is 1. It clears on `thr_wr`, or on `isr_rd` while the code reads 0010, and clearing wins over setting. The flag is reported only while `ier[1]` is set.
- R9: `isr_code` reports only the highest pending source: 0110 for line status, then 0100 for receive data, then 0010 for transmit empty, and 0001 when nothing is pending.
- R10: `irq` is high exactly when `isr_code` is not 0001.
- R11: With `fifo_en` high and `ier` all zero, `irq` stays low while `lsr` keeps following its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | 6 | Receive FIFO fill count |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_err | input | 4 | Error flags of the pushed character |
| rx_bad | input | 1 | At least one queued receive entry is errored |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_idle | input | 1 | Transmit shift register idle |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| lsr_rd | input | 1 | Line status read strobe |
| isr_rd | input | 1 | Interrupt status read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| ier | output | 4 | Interrupt enable register |
| lsr | output | 8 | Line status byte |
| isr_code | output | 4 | Highest pending interrupt code |
| irq | output | 1 | Interrupt request |

## Verification
The receive count is ramped up and down across each of the four trigger levels, and also with FIFO mode off. This separates an off-by-one threshold from a wrong level select and from a latched rather than level-following interrupt. Error pushes coincide with status reads, and they are combined with receive and transmit sources. This shows the priority order and whether a read drops a same-cycle error. Transmit-empty edges are cleared by each of its two acknowledges in turn. A long stretch of random stimulus is then compared every cycle against a behavioural model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ISR_NONE = 4'b0001,
    ISR_TXE  = 4'b0010,
    ISR_RXD  = 4'b0100,
    ISR_LSE  = 4'b0110
  } isr_code_e;
endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] wdata,
  output logic [IW-1:0] ier_q,
  output logic          tx_arm
);
  logic [IW-1:0] ier_d;

  always_comb begin
    ier_d = ier_q;
    if (wr) ier_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else        ier_q <= ier_d;
  end

  // bit 1 going from 0 to 1 re-arms the transmit-empty source
  assign tx_arm = wr & wdata[1] & ~ier_q[1];
endmodule

// File: rtl/uart_lsr_track.sv
module uart_lsr_track #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic [3:0]       rx_err,
  input  logic             rx_bad,
  input  logic             tx_empty,
  input  logic             tx_idle,
  input  logic             lsr_rd,
  output logic [7:0]       lsr,
  output logic             err_any
);
  logic [3:0] err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (lsr_rd)  err_d = '0;
    if (rx_push) err_d = err_d | rx_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  assign err_any = |err_q;
  assign lsr = {rx_bad, tx_empty & tx_idle, tx_empty, err_q, (rx_count != '0)};
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [2:0]       ier_src,
  input  logic             err_any,
  input  logic             tx_empty,
  input  logic             tx_arm,
  input  logic             thr_wr,
  input  logic             isr_rd,
  output isr_code_e        isr_code,
  output logic             irq
);
  localparam int NLVL = 4;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lvl_tab [NLVL];
  logic [CNT_W-1:0] lvl;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    if (g == NLVL - 1) begin : g_top
      assign lvl_tab[g] = CNT_W'(DEPTH - DEPTH / 8);
    end else begin : g_step
      assign lvl_tab[g] = CNT_W'((g + 1) * DEPTH / NLVL);
    end
  end

  assign lvl = fifo_en ? lvl_tab[trig_sel] : ONE;

  logic rxd_pend, lse_pend, txe_pend;
  logic tx_q, tx_q_d, txf_q, txf_d, tx_set, tx_clr;

  assign rxd_pend = ier_src[0] & (rx_count >= lvl);
  assign lse_pend = ier_src[2] & err_any;
  assign txe_pend = ier_src[1] & txf_q;

  always_comb begin
    if (lse_pend)      isr_code = ISR_LSE;
    else if (rxd_pend) isr_code = ISR_RXD;
    else if (txe_pend) isr_code = ISR_TXE;
    else               isr_code = ISR_NONE;
  end

  assign irq = lse_pend | rxd_pend | txe_pend;

  assign tx_set = (tx_empty & ~tx_q) | (tx_arm & tx_empty);
  assign tx_clr = thr_wr | (isr_rd & (isr_code == ISR_TXE));

  always_comb begin
    txf_d  = txf_q;
    tx_q_d = tx_empty;
    if (tx_clr)      txf_d = 1'b0;
    else if (tx_set) txf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txf_q <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      txf_q <= txf_d;
      tx_q  <= tx_q_d;
    end
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic [3:0]       rx_err,
  input  logic             rx_bad,
  input  logic             tx_empty,
  input  logic             tx_idle,
  input  logic             ier_wr,
  input  logic [3:0]       ier_wdata,
  input  logic             lsr_rd,
  input  logic             isr_rd,
  input  logic             thr_wr,
  output logic [3:0]       ier,
  output logic [7:0]       lsr,
  output logic [3:0]       isr_code,
  output logic             irq
);
  logic      tx_arm, err_any;
  isr_code_e code;

  uart_ier_reg #(.IW(4)) u_ier (
    .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
    .ier_q(ier), .tx_arm(tx_arm)
  );

  uart_lsr_track #(.CNT_W(CNT_W)) u_lsr (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_push(rx_push),
    .rx_err(rx_err), .rx_bad(rx_bad), .tx_empty(tx_empty), .tx_idle(tx_idle),
    .lsr_rd(lsr_rd), .lsr(lsr), .err_any(err_any)
  );

  uart_irq_arb #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rx_count(rx_count), .ier_src(ier[2:0]), .err_any(err_any),
    .tx_empty(tx_empty), .tx_arm(tx_arm), .thr_wr(thr_wr), .isr_rd(isr_rd),
    .isr_code(code), .irq(irq)
  );

  assign isr_code = code;
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_push,
  input logic [3:0]       ier_wdata,
  input logic             ier_wr,
  input logic             lsr_rd,
  input logic             thr_wr,
  input logic [3:0]       ier,
  input logic [7:0]       lsr,
  input logic [3:0]       isr_code,
  input logic             irq
);
  int lvl;
  always_comb begin
    if (!fifo_en) lvl = 1;
    else case (trig_sel)
      2'd0:    lvl = DEPTH / 4;
      2'd1:    lvl = DEPTH / 2;
      2'd2:    lvl = 3 * DEPTH / 4;
      default: lvl = DEPTH - DEPTH / 8;
    endcase
  end

  // R1
  ier_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier == $past(ier_wdata));

  // R2
  rxd_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_code == 4'b0100) |-> (ier[0] && int'(rx_count) >= lvl));

  // R5
  err_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_push) |=> lsr[4:1] == 4'b0000);

  // R6
  temt_implies_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);

  // R8
  thr_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> isr_code != 4'b0010);

  // R11
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && ier == 4'b0000) |-> !irq);
endmodule

bind uart_irq_status uart_irq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
  .rx_count(rx_count), .rx_push(rx_push), .ier_wdata(ier_wdata),
  .ier_wr(ier_wr), .lsr_rd(lsr_rd), .thr_wr(thr_wr), .ier(ier), .lsr(lsr),
  .isr_code(isr_code), .irq(irq)
);

// File: tb/tb_uart_irq_status.sv
`timescale 1ns/1ps
module tb_uart_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, rx_push = 1'b0, rx_bad = 1'b0;
  logic tx_empty = 1'b0, tx_idle = 1'b0;
  logic ier_wr = 1'b0, lsr_rd = 1'b0, isr_rd = 1'b0, thr_wr = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [5:0] rx_count = 6'd0;
  logic [3:0] rx_err = 4'd0, ier_wdata = 4'd0;
  logic [3:0] ier, isr_code;
  logic [7:0] lsr;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_status dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rx_count(rx_count), .rx_push(rx_push), .rx_err(rx_err), .rx_bad(rx_bad),
    .tx_empty(tx_empty), .tx_idle(tx_idle), .ier_wr(ier_wr),
    .ier_wdata(ier_wdata), .lsr_rd(lsr_rd), .isr_rd(isr_rd), .thr_wr(thr_wr),
    .ier(ier), .lsr(lsr), .isr_code(isr_code), .irq(irq)
  );

  // behavioural reference state
  bit [3:0] m_ier, m_err;
  bit m_pend, m_txq;

  function automatic int m_lvl();
    if (!fifo_en) return 1;
    case (trig_sel)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 24;
      default: return 28;
    endcase
  endfunction

  function automatic bit [3:0] m_code();
    if (m_ier[2] && m_err != 0) return 4'b0110;
    if (m_ier[0] && int'(rx_count) >= m_lvl()) return 4'b0100;
    if (m_ier[1] && m_pend) return 4'b0010;
    return 4'b0001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier = 0; m_err = 0; m_pend = 0; m_txq = 0;
    end else begin
      bit [3:0] c;
      bit s, k;
      c = m_code();
      s = (tx_empty && !m_txq) || (ier_wr && ier_wdata[1] && !m_ier[1] && tx_empty);
      k = thr_wr || (isr_rd && c == 4'b0010);
      if (k) m_pend = 0; else if (s) m_pend = 1;
      m_err = (lsr_rd ? 4'b0 : m_err) | (rx_push ? rx_err : 4'b0);
      if (ier_wr) m_ier = ier_wdata;
      m_txq = tx_empty;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit [3:0] c;
      c = m_code();
      chk(ier == m_ier, "R1", ier, m_ier);
      chk(lsr[0] == (rx_count != 0), "R4", lsr[0], rx_count != 0);
      chk(lsr[4:1] == m_err, "R5", lsr[4:1], m_err);
      chk(lsr[7:5] == {rx_bad, tx_empty & tx_idle, tx_empty}, "R6", lsr[7:5],
          {rx_bad, tx_empty & tx_idle, tx_empty});
      chk(isr_code == c, "R9", isr_code, c);
      chk(irq == (c != 4'b0001), "R10", irq, c != 4'b0001);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    ier_wr = 0; lsr_rd = 0; isr_rd = 0; thr_wr = 0; rx_push = 0;
  endtask

  task automatic wr_ier(input bit [3:0] v);
    ier_wr = 1; ier_wdata = v; tick();
  endtask

  task automatic expect_code(input bit [3:0] e, input string req);
    @(negedge clk);
    chk(isr_code == e, req, isr_code, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ier == 0 && irq == 0, "R1", {ier, irq}, 0);

    // R2 R3: trigger crossing up and down, level 8
    fifo_en = 1; wr_ier(4'b0001);
    rx_count = 7; expect_code(4'b0001, "R3");
    tick(); rx_count = 8; rx_push = 1; expect_code(4'b0100, "R3");
    tick(); rx_count = 7; expect_code(4'b0001, "R2");
    // level 28
    tick(); trig_sel = 3; rx_count = 27; expect_code(4'b0001, "R3");
    tick(); rx_count = 28; expect_code(4'b0100, "R3");
    tick(); trig_sel = 2; rx_count = 23; expect_code(4'b0001, "R3");
    tick(); rx_count = 24; expect_code(4'b0100, "R3");
    tick(); trig_sel = 1; rx_count = 15; expect_code(4'b0001, "R3");
    // non-FIFO mode: level 1
    tick(); fifo_en = 0; rx_count = 1; expect_code(4'b0100, "R2");
    tick(); rx_count = 0; fifo_en = 1; trig_sel = 0;

    // R7 R9: error outranks receive data
    wr_ier(4'b0101);
    rx_count = 9; rx_push = 1; rx_err = 4'b0010; tick();
    expect_code(4'b0110, "R7");
    tick(); lsr_rd = 1; rx_push = 1; rx_err = 4'b1000; tick();
    @(negedge clk); chk(lsr[4:1] == 4'b1000, "R5", lsr[4:1], 4'b1000);
    tick(); lsr_rd = 1; tick(); expect_code(4'b0100, "R9");
    rx_count = 0;

    // R8: transmit empty, cleared by status read then by THR write
    wr_ier(4'b0010);
    tx_empty = 1; tx_idle = 1; tick(); expect_code(4'b0010, "R8");
    tick(); isr_rd = 1; tick(); expect_code(4'b0001, "R8");
    tx_empty = 0; tick(); tx_empty = 1; tick(); expect_code(4'b0010, "R8");
    tick(); thr_wr = 1; tick(); expect_code(4'b0001, "R8");
    wr_ier(4'b0000); wr_ier(4'b0010); expect_code(4'b0010, "R8");

    // R11: polled mode
    wr_ier(4'b0000);
    rx_count = 30; rx_bad = 1; rx_push = 1; rx_err = 4'b0100; tick();
    @(negedge clk);
    chk(irq == 0, "R11", irq, 0);
    chk(lsr == 8'b1110_1001, "R11", lsr, 8'b1110_1001);

    // random phase, checked every cycle by the model
    for (int i = 0; i < 3000; i++) begin
      fifo_en = ($urandom % 8) != 0; trig_sel = 2'($urandom);
      rx_count = 6'($urandom % 33); rx_push = ($urandom % 4) == 0;
      rx_err = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
      rx_bad = $urandom % 2; tx_empty = ($urandom % 3) != 0; tx_idle = $urandom % 2;
      ier_wr = ($urandom % 10) == 0; ier_wdata = 4'($urandom);
      lsr_rd = ($urandom % 6) == 0; isr_rd = ($urandom % 4) == 0;
      thr_wr = ($urandom % 8) == 0;
      @(posedge clk); #1;
    end
    tick(); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule